// File: doc/BRIEF.md
# Bidirectional Control Endpoint FIFO

This block is the data buffer of a USB device's control endpoint: one 16-entry, 8-bit FIFO that carries traffic in either direction, with an internal sequencer that alone decides which way it flows. At rest the sequencer waits in a receive state. The host side loads setup bytes into the FIFO there, and once a full command of eight bytes is stored a one-cycle interrupt tells the local processor to pop them.

If the request decoder, which sits outside this block, finds that the command needs data sent back, it strobes a reply request. The sequencer then discards what is left of the command and turns the FIFO to transmit. The processor pushes the reply bytes and the host side drains them. When the host side pops the last byte, or when a new setup phase begins, the FIFO is flushed and the block goes back to idle receive.

Software reads a 32-bit byte-count register whose low byte holds the occupancy minus one. A separate empty flag covers the case the count field cannot show.

Top module: `ctl_ep_fifo`

## Requirements
- R1: After reset the FIFO is empty (`fifo_empty` = 1), `byte_count_reg` reads 0, `dir_tx` = 0 (receive) and `cmd_irq` = 0.
- R2: In the idle receive state each `host_wr_valid` cycle stores `host_wr_data`. `proc_wr` has no effect on the contents or on the count there.
- R3: The edge that stores the eighth command byte raises `cmd_irq` for exactly one cycle, and the block enters the command-held state. Host bytes offered while in that state are ignored.
- R4: In the command-held state, a `proc_rd` cycle pops one byte. The byte appears on `proc_rd_data` after the next clock edge, and bytes come out in the order they arrived.
- R5: `byte_count_reg[7:0]` equals the occupancy minus one and changes on the edge of every push or pop. It reads 0 when the FIFO is empty, and `byte_count_reg[31:8]` always reads 0.
- R6: A `proc_rd` while the FIFO is empty, or outside the command-held state, leaves `proc_rd_data` and the count unchanged.
- R7: `reply_needed` in the command-held state flushes any unread command bytes and sets `dir_tx` = 1 with the FIFO empty. In any other state it is ignored.
- R8: In the transmit state each `proc_wr` cycle stores `proc_wr_data` until 16 bytes are held (`fifo_full` = 1). Any further writes are dropped.
- R9: In the transmit state a `host_rd` cycle pops one byte onto `host_rd_data` after the next edge, in write order. A `host_rd` on an empty FIFO changes neither `host_rd_data` nor the state.
- R10: A host pop that takes the last byte of the transmit phase flushes the FIFO and returns the block to idle receive (`dir_tx` = 0).
- R11: `host_setup` in any state empties the FIFO and puts the block in idle receive on the next edge, whatever the other inputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_setup | input | 1 | Start of a setup phase: flush and return to idle |
| host_wr_valid | input | 1 | Host side offers a command byte |
| host_wr_data | input | 8 | Command byte from the host side |
| host_rd | input | 1 | Host side pops a reply byte |
| host_rd_data | output | 8 | Last reply byte popped by the host side |
| reply_needed | input | 1 | Decoder strobe: the held command needs a reply |
| proc_wr | input | 1 | Processor pushes a reply byte |
| proc_wr_data | input | 8 | Reply byte from the processor |
| proc_rd | input | 1 | Processor pops a command byte |
| proc_rd_data | output | 8 | Last command byte popped by the processor |
| byte_count_reg | output | 32 | Read-only count register: occupancy minus one in bits 7:0 |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| dir_tx | output | 1 | 1 when the FIFO flows toward the host |
| cmd_irq | output | 1 | One-cycle pulse when a full command is stored |

## Verification
The assertions assume that every input is a clean single-cycle level sampled at the rising edge. They do not assume that strobes are mutually exclusive, because the sequencer itself ranks `host_setup` above everything else and `reply_needed` above a processor pop. The stimulus changes inputs only on the falling edge and raises one strobe at a time, except where a test deliberately offers an ignored request, such as host bytes during the held state or processor writes during idle. The checks on the count register treat it as a minus-one value and read the empty flag alongside it to tell zero bytes from one.

// File: rtl/ctl_ep_pkg.sv
// Package: shared types for the control endpoint FIFO.
// Assumes: nothing beyond a standard elaboration order (compiled first).
package ctl_ep_pkg;
    typedef enum logic [1:0] {
        EP_IDLE     = 2'd0,
        EP_CMD_HELD = 2'd1,
        EP_TX       = 2'd2
    } ep_state_e;
endpackage

// File: rtl/ep_fifo_store.sv
// Module: ep_fifo_store
// Storage array with read/write pointers and an occupancy counter.
// Assumes: push and pop arrive already gated against full and empty;
// flush takes precedence over both pointer updates.
module ep_fifo_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write the incoming byte into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance pointers and occupancy; flush resets them all.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Present the head byte and the occupancy flags.
    always_comb begin
        rdata = mem[rd_ptr];
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end
endmodule

// File: rtl/ep_seq.sv
// Module: ep_seq
// Direction sequencer: idle receive, command held, transmit.
// Assumes: host_setup outranks every other request; reply_needed outranks
// a processor pop in the held state; CMD_LEN does not exceed the depth.
module ep_seq
    import ctl_ep_pkg::*;
#(
    parameter int CW      = 5,
    parameter int CMD_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_setup,
    input  logic          host_wr_valid,
    input  logic          host_rd,
    input  logic          reply_needed,
    input  logic          proc_wr,
    input  logic          proc_rd,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic          empty,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          from_proc,
    output ep_state_e     state,
    output logic          irq
);
    ep_state_e nxt;
    logic      irq_nxt;

    // Decide the accepted push/pop, flushes and the next state.
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        flush     = 1'b0;
        irq_nxt   = 1'b0;
        nxt       = state;
        from_proc = (state == EP_TX);
        if (host_setup) begin
            flush = 1'b1;
            nxt   = EP_IDLE;
        end else begin
            case (state)
                EP_IDLE: begin
                    if (host_wr_valid && !full) begin
                        push = 1'b1;
                        if (count == CW'(CMD_LEN - 1)) begin
                            nxt     = EP_CMD_HELD;
                            irq_nxt = 1'b1;
                        end
                    end
                end
                EP_CMD_HELD: begin
                    if (reply_needed) begin
                        flush = 1'b1;
                        nxt   = EP_TX;
                    end else if (proc_rd && !empty) begin
                        pop = 1'b1;
                    end
                end
                EP_TX: begin
                    push = proc_wr && !full;
                    pop  = host_rd && !empty;
                    if (pop && !push && count == CW'(1)) begin
                        flush = 1'b1;
                        nxt   = EP_IDLE;
                    end
                end
                default: nxt = EP_IDLE;
            endcase
        end
    end

    // Register the state and the one-cycle command interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= EP_IDLE;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            irq   <= irq_nxt;
        end
    end
endmodule

// File: rtl/ep_count_reg.sv
// Module: ep_count_reg
// Formats occupancy into the read-only register: occupancy minus one in
// the low field, zero when empty, upper bits reading zero.
// Assumes: REG_W is at least BC_W and BC_W can hold DEPTH - 1.
module ep_count_reg #(
    parameter int CW    = 5,
    parameter int BC_W  = 8,
    parameter int REG_W = 32
) (
    input  logic [CW-1:0]    count,
    output logic [REG_W-1:0] reg_val
);
    logic [BC_W-1:0] field;

    // Build the minus-one field and zero-extend it.
    always_comb begin
        field   = (count == '0) ? '0 : BC_W'(count - 1'b1);
        reg_val = REG_W'(field);
    end
endmodule

// File: rtl/ctl_ep_fifo.sv
// Module: ctl_ep_fifo (top)
// Control endpoint FIFO shared by both directions, steered by ep_seq.
// Assumes: single clock, synchronous active-low reset, one-cycle strobes.
module ctl_ep_fifo
    import ctl_ep_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter int CMD_LEN = 8,
    parameter int BC_W    = 8,
    parameter int REG_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_setup,
    input  logic             host_wr_valid,
    input  logic [DW-1:0]    host_wr_data,
    input  logic             host_rd,
    output logic [DW-1:0]    host_rd_data,
    input  logic             reply_needed,
    input  logic             proc_wr,
    input  logic [DW-1:0]    proc_wr_data,
    input  logic             proc_rd,
    output logic [DW-1:0]    proc_rd_data,
    output logic [REG_W-1:0] byte_count_reg,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             dir_tx,
    output logic             cmd_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, flush, from_proc;
    logic [CW-1:0] count;
    logic [DW-1:0] wdata, rdata;
    ep_state_e     state_q;

    ep_seq #(.CW(CW), .CMD_LEN(CMD_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .host_setup(host_setup),
        .host_wr_valid(host_wr_valid), .host_rd(host_rd),
        .reply_needed(reply_needed), .proc_wr(proc_wr), .proc_rd(proc_rd),
        .count(count), .full(fifo_full), .empty(fifo_empty),
        .push(push), .pop(pop), .flush(flush), .from_proc(from_proc),
        .state(state_q), .irq(cmd_irq)
    );

    ep_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .wdata(wdata), .rdata(rdata), .count(count),
        .full(fifo_full), .empty(fifo_empty)
    );

    ep_count_reg #(.CW(CW), .BC_W(BC_W), .REG_W(REG_W)) u_bc (
        .count(count), .reg_val(byte_count_reg)
    );

    // Select the write source from the current direction.
    always_comb begin
        wdata  = from_proc ? proc_wr_data : host_wr_data;
        dir_tx = (state_q == EP_TX);
    end

    // Capture popped bytes on the side that owns the current direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proc_rd_data <= '0;
            host_rd_data <= '0;
        end else if (pop) begin
            if (state_q == EP_TX) begin
                host_rd_data <= rdata;
            end else begin
                proc_rd_data <= rdata;
            end
        end
    end
endmodule

// File: rtl/ctl_ep_fifo_chk.sv
// Module: ctl_ep_fifo_chk
// Temporal checks on the endpoint FIFO, attached by bind to the top.
// Assumes: observed signals are sampled at the rising edge after reset.
module ctl_ep_fifo_chk
    import ctl_ep_pkg::*;
#(
    parameter int DW   = 8,
    parameter int BC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_setup,
    input logic            host_wr_valid,
    input logic            proc_wr,
    input logic            proc_rd,
    input logic            reply_needed,
    input ep_state_e       state,
    input logic [BC_W-1:0] bc,
    input logic            fifo_empty,
    input logic            dir_tx,
    input logic            cmd_irq,
    input logic [DW-1:0]   proc_rd_data
);
    assert_proc_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EP_IDLE && proc_wr && !host_wr_valid && !host_setup)
        |=> ($stable(bc) && $stable(fifo_empty)));

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |=> !cmd_irq);

    assert_irq_in_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> (state == EP_CMD_HELD));

    assert_empty_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (bc == '0));

    assert_stale_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rd && (fifo_empty || state != EP_CMD_HELD)) |=> $stable(proc_rd_data));

    assert_reply_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == EP_CMD_HELD && reply_needed && !host_setup)
        |=> (dir_tx && fifo_empty));

    assert_setup_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_setup |=> (fifo_empty && !dir_tx && state == EP_IDLE));
endmodule

bind ctl_ep_fifo ctl_ep_fifo_chk #(.DW(DW), .BC_W(BC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_setup(host_setup),
    .host_wr_valid(host_wr_valid), .proc_wr(proc_wr), .proc_rd(proc_rd),
    .reply_needed(reply_needed), .state(state_q), .bc(byte_count_reg[BC_W-1:0]),
    .fifo_empty(fifo_empty), .dir_tx(dir_tx), .cmd_irq(cmd_irq),
    .proc_rd_data(proc_rd_data)
);

// File: tb/tb_ctl_ep_fifo.sv
`timescale 1ns/1ps
// Bench for ctl_ep_fifo: scoreboard queues fed by driver tasks, monitors
// compare popped bytes one clock after each pop request.
module tb_ctl_ep_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_setup = 1'b0, host_wr_valid = 1'b0, host_rd = 1'b0;
    logic        reply_needed = 1'b0, proc_wr = 1'b0, proc_rd = 1'b0;
    logic [7:0]  host_wr_data = '0, proc_wr_data = '0;
    logic [7:0]  host_rd_data, proc_rd_data;
    logic [31:0] byte_count_reg;
    logic        fifo_empty, fifo_full, dir_tx, cmd_irq;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   mon_proc = 1'b0, mon_host = 1'b0, done = 1'b0;
    logic [7:0] q_proc[$];
    logic [7:0] q_host[$];

    always #2 clk = ~clk;

    ctl_ep_fifo dut (
        .clk(clk), .rst_n(rst_n), .host_setup(host_setup),
        .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data),
        .host_rd(host_rd), .host_rd_data(host_rd_data),
        .reply_needed(reply_needed), .proc_wr(proc_wr),
        .proc_wr_data(proc_wr_data), .proc_rd(proc_rd),
        .proc_rd_data(proc_rd_data), .byte_count_reg(byte_count_reg),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .dir_tx(dir_tx),
        .cmd_irq(cmd_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: processor-side pops (R4)
    always @(posedge clk) begin
        if (mon_proc) begin
            logic [7:0] e;
            #1;
            e = q_proc.pop_front();
            chk(proc_rd_data == e, "R4", {24'd0, proc_rd_data}, {24'd0, e});
        end
    end

    // Monitor: host-side pops (R9)
    always @(posedge clk) begin
        if (mon_host) begin
            logic [7:0] e;
            #1;
            e = q_host.pop_front();
            chk(host_rd_data == e, "R9", {24'd0, host_rd_data}, {24'd0, e});
        end
    end

    task automatic host_push(input logic [7:0] b);
        host_wr_valid = 1'b1; host_wr_data = b;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic proc_push(input logic [7:0] b, input bit accepted);
        if (accepted) q_host.push_back(b);
        proc_wr = 1'b1; proc_wr_data = b;
        @(negedge clk);
        proc_wr = 1'b0;
    endtask

    task automatic proc_pop_exp(input logic [7:0] b);
        q_proc.push_back(b);
        proc_rd = 1'b1; mon_proc = 1'b1;
        @(negedge clk);
        proc_rd = 1'b0; mon_proc = 1'b0;
    endtask

    task automatic host_pop_exp();
        host_rd = 1'b1; mon_host = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; mon_host = 1'b0;
    endtask

    task automatic pulse_reply();
        reply_needed = 1'b1;
        @(negedge clk);
        reply_needed = 1'b0;
    endtask

    task automatic pulse_setup();
        host_setup = 1'b1;
        @(negedge clk);
        host_setup = 1'b0;
    endtask

    task automatic load_command(input logic [7:0] base);
        for (int i = 0; i < 8; i++) begin
            host_push(base + 8'(i));
            if (i == 4) chk(byte_count_reg == 32'd4, "R5", byte_count_reg, 32'd4);
        end
        chk(cmd_irq == 1'b1, "R3", {31'd0, cmd_irq}, 32'd1);
        @(negedge clk);
        chk(cmd_irq == 1'b0, "R3", {31'd0, cmd_irq}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(fifo_empty == 1'b1, "R1", {31'd0, fifo_empty}, 32'd1);
        chk(byte_count_reg == 32'd0, "R1", byte_count_reg, 32'd0);
        chk(dir_tx == 1'b0, "R1", {31'd0, dir_tx}, 32'd0);
        chk(cmd_irq == 1'b0, "R1", {31'd0, cmd_irq}, 32'd0);

        // R2: processor writes ignored in idle
        for (int i = 0; i < 3; i++) proc_push(8'h11, 1'b0);
        chk(fifo_empty == 1'b1, "R2", {31'd0, fifo_empty}, 32'd1);
        chk(byte_count_reg == 32'd0, "R2", byte_count_reg, 32'd0);

        // R3/R5: first command with interrupt
        load_command(8'hA0);
        host_push(8'hEE);
        host_push(8'hEF);
        chk(byte_count_reg == 32'd7, "R3", byte_count_reg, 32'd7);

        // R4/R5: partial read-out, count after each pop
        for (int i = 0; i < 3; i++) begin
            proc_pop_exp(8'hA0 + 8'(i));
            chk(byte_count_reg == 32'(6 - i), "R5", byte_count_reg, 32'(6 - i));
        end

        // R7: reply request flushes and turns direction
        pulse_reply();
        chk(dir_tx == 1'b1, "R7", {31'd0, dir_tx}, 32'd1);
        chk(fifo_empty == 1'b1, "R7", {31'd0, fifo_empty}, 32'd1);

        // R6: processor read in transmit state ignored
        proc_rd = 1'b1; @(negedge clk); proc_rd = 1'b0;
        chk(proc_rd_data == 8'hA2, "R6", {24'd0, proc_rd_data}, 32'hA2);

        // R9: host read on empty FIFO ignored
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk(host_rd_data == 8'h00, "R9", {24'd0, host_rd_data}, 32'h0);
        chk(dir_tx == 1'b1, "R9", {31'd0, dir_tx}, 32'd1);

        // R8: fill to 16, drop overflow
        for (int i = 0; i < 18; i++) proc_push(8'h50 + 8'(i), i < 16);
        chk(byte_count_reg == 32'd15, "R8", byte_count_reg, 32'd15);
        chk(fifo_full == 1'b1, "R8", {31'd0, fifo_full}, 32'd1);

        // R9/R10: host drains in order, last pop returns to idle
        for (int i = 0; i < 15; i++) host_pop_exp();
        chk(byte_count_reg == 32'd0 && !fifo_empty, "R5", byte_count_reg, 32'd0);
        chk(dir_tx == 1'b1, "R10", {31'd0, dir_tx}, 32'd1);
        host_pop_exp();
        chk(dir_tx == 1'b0, "R10", {31'd0, dir_tx}, 32'd0);
        chk(fifo_empty == 1'b1, "R10", {31'd0, fifo_empty}, 32'd1);

        // Second command fully read, then empty read ignored
        load_command(8'hB0);
        for (int i = 0; i < 8; i++) proc_pop_exp(8'hB0 + 8'(i));
        chk(fifo_empty == 1'b1 && byte_count_reg == 32'd0, "R5", byte_count_reg, 32'd0);
        proc_rd = 1'b1; @(negedge clk); proc_rd = 1'b0;
        chk(proc_rd_data == 8'hB7, "R6", {24'd0, proc_rd_data}, 32'hB7);
        chk(byte_count_reg == 32'd0, "R6", byte_count_reg, 32'd0);

        // R11: setup from held state reopens receive
        pulse_setup();
        host_push(8'hD0);
        chk(byte_count_reg == 32'd0 && !fifo_empty, "R11", {31'd0, fifo_empty}, 32'd0);
        pulse_setup();
        chk(fifo_empty == 1'b1, "R11", {31'd0, fifo_empty}, 32'd1);

        // R11: setup in the middle of a transmit phase
        load_command(8'hC0);
        pulse_reply();
        proc_push(8'h71, 1'b0);
        proc_push(8'h72, 1'b0);
        chk(byte_count_reg == 32'd1, "R8", byte_count_reg, 32'd1);
        pulse_setup();
        chk(dir_tx == 1'b0 && fifo_empty, "R11", {31'd0, dir_tx}, 32'd0);
        proc_push(8'h73, 1'b0);
        chk(fifo_empty == 1'b1, "R2", {31'd0, fifo_empty}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule